// File: doc/BRIEF.md
# T1 Clear-Channel Transmit Octet Processor

This block sits in the transmit path of a T1 framer and handles one payload octet per handshake. Each octet comes with its timeslot number (1 to 24) and its frame number within a 12-frame superframe. The block writes the per-channel A/B signaling bits into the octet's least significant bit in the signaling frames. It then applies zero-code suppression so that no all-zero octet reaches the line. Last, it clears the remote alarm bit when the alarm is raised.

A 24-bit clear-channel mask, supplied as three 8-bit banks, exempts chosen timeslots from both signaling insertion and zero-code suppression. This allows data channels to pass through unchanged. The mask does not protect a timeslot from the remote alarm, which is applied to every octet.

Both stream edges use a valid/ready handshake with a single output register, so the latency is one cycle. An octet is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output octet is held unchanged and no new octet is taken. Control pins (mask banks, signaling bits, enables, alarm) are plain levels, sampled on the edge that takes the octet.

Top module: `t1ccx_tx`

## Requirements
- R1: An octet is accepted on a clock edge where in_valid and in_ready are high, and appears on out_octet with out_valid high after that edge. in_ready is low exactly when out_valid is high and out_ready is low. While stalled, out_valid and out_octet hold their values.
- R2: After reset, out_valid is low and in_ready is high.
- R3: The mask is {clr_bank2, clr_bank1, clr_bank0}: bit k of clr_bankN marks timeslot 8*N+k+1 as clear (bank 0 bit 0 is timeslot 1, bank 2 bit 7 is timeslot 24).
- R4: For a non-clear timeslot s with sig_en high, frame 6 replaces out bit 0 (the LSB) with sig_a[s-1], and frame 12 replaces it with sig_b[s-1]. Other frames leave bit 0 as received.
- R5: For a non-clear timeslot with zcs_en high, an octet that is 8'h00 after signaling insertion is sent as 8'h02 (bit 7 counted from the MSB forced to 1).
- R6: An octet in a clear timeslot is never altered by signaling insertion or zero-code suppression, whatever the enables and signaling bits are.
- R7: With ralarm high, bit 6 of every outgoing octet (bit 2 counted from the MSB) is 0 in every timeslot, including clear ones. This is applied after the other steps.
- R8: With sig_en low, no channel gets signaling. With zcs_en low, no channel gets zero-code suppression. With both low and ralarm low, octets pass unchanged.
- R9: A timeslot number outside 1..24 receives neither signaling nor zero-code suppression. A frame number other than 6 or 12 receives no signaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input octet valid |
| in_ready | output | 1 | Block can take an octet |
| in_octet | input | 8 | Payload octet, bit 7 is the first bit on the line |
| in_slot | input | 5 | Timeslot number, 1..24 |
| in_frame | input | 4 | Frame number in superframe, 1..12 |
| sig_a | input | 24 | A signaling bit per channel, bit s-1 for timeslot s |
| sig_b | input | 24 | B signaling bit per channel, bit s-1 for timeslot s |
| clr_bank0 | input | 8 | Clear-channel mask, timeslots 1..8 |
| clr_bank1 | input | 8 | Clear-channel mask, timeslots 9..16 |
| clr_bank2 | input | 8 | Clear-channel mask, timeslots 17..24 |
| sig_en | input | 1 | Global enable of signaling insertion |
| zcs_en | input | 1 | Global enable of zero-code suppression |
| ralarm | input | 1 | Remote alarm insertion |
| out_valid | output | 1 | Output octet valid |
| out_ready | input | 1 | Downstream can take the octet |
| out_octet | output | 8 | Processed octet |

## Verification
On every cycle, the assertions check the handshake and stall hold rules. They also check that an accepted octet in a clear timeslot comes out unchanged when no alarm is present, that an alarm always leaves the alarm bit cleared, that a non-clear in-range octet with suppression enabled never leaves as all zero, and that all-disabled operation is transparent. The exact values of the signaling bits that land in frames 6 and 12, the mapping of mask bits to timeslots across the three banks, and the handling of out-of-range slot and frame numbers are shown only by the bench's scenarios. In those scenarios, a behavioural model predicts every output octet under changing masks, enables and back-pressure.

// File: rtl/t1ccx_pkg.sv
package t1ccx_pkg;
  localparam int OCT_W     = 8;
  localparam int FRM_W     = 4;
  localparam int FRAME_A   = 6;
  localparam int FRAME_B   = 12;
  localparam int SIG_POS   = 0;
  localparam int ZCS_POS   = 1;
  localparam int ALARM_POS = 6;

  typedef logic [OCT_W-1:0] octet_t;

  typedef struct packed {
    logic clear;
    logic in_range;
    logic a_bit;
    logic b_bit;
  } chan_info_t;
endpackage

// File: rtl/t1ccx_slot_sel.sv
module t1ccx_slot_sel
  import t1ccx_pkg::*;
#(
  parameter int NCH    = 24,
  parameter int SLOT_W = 5
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [NCH-1:0]    mask,
  input  logic [NCH-1:0]    sig_a,
  input  logic [NCH-1:0]    sig_b,
  output chan_info_t        info
);
  logic [NCH-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_dec
      assign hit[g] = (slot == SLOT_W'(g + 1));
    end
  endgenerate

  always_comb begin
    info.in_range = |hit;
    info.clear    = |(hit & mask);
    info.a_bit    = |(hit & sig_a);
    info.b_bit    = |(hit & sig_b);
  end
endmodule

// File: rtl/t1ccx_sig_ins.sv
module t1ccx_sig_ins
  import t1ccx_pkg::*;
(
  input  octet_t            din,
  input  logic [FRM_W-1:0]  frame,
  input  logic              apply,
  input  logic              a_bit,
  input  logic              b_bit,
  output octet_t            dout
);
  logic is_a, is_b;

  always_comb begin
    is_a = (frame == FRM_W'(FRAME_A));
    is_b = (frame == FRM_W'(FRAME_B));
    dout = din;
    if (apply && is_a) dout[SIG_POS] = a_bit;
    else if (apply && is_b) dout[SIG_POS] = b_bit;
  end
endmodule

// File: rtl/t1ccx_zcs.sv
module t1ccx_zcs
  import t1ccx_pkg::*;
(
  input  octet_t din,
  input  logic   apply,
  output octet_t dout
);
  always_comb begin
    dout = din;
    if (apply && (din == '0)) dout[ZCS_POS] = 1'b1;
  end
endmodule

// File: rtl/t1ccx_tx.sv
module t1ccx_tx
  import t1ccx_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int NBANK  = 3,
  parameter int SLOT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_octet,
  input  logic [SLOT_W-1:0]       in_slot,
  input  logic [3:0]              in_frame,
  input  logic [BANK_W*NBANK-1:0] sig_a,
  input  logic [BANK_W*NBANK-1:0] sig_b,
  input  logic [BANK_W-1:0]       clr_bank0,
  input  logic [BANK_W-1:0]       clr_bank1,
  input  logic [BANK_W-1:0]       clr_bank2,
  input  logic                    sig_en,
  input  logic                    zcs_en,
  input  logic                    ralarm,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_octet
);
  localparam int NCH = BANK_W * NBANK;

  logic [NCH-1:0] mask;
  chan_info_t     info;
  octet_t         after_sig, after_zcs, final_oct;
  logic           modify_ok;
  logic           take;

  assign mask = {clr_bank2, clr_bank1, clr_bank0};

  t1ccx_slot_sel #(.NCH(NCH), .SLOT_W(SLOT_W)) u_sel (
    .slot  (in_slot),
    .mask  (mask),
    .sig_a (sig_a),
    .sig_b (sig_b),
    .info  (info)
  );

  assign modify_ok = info.in_range && !info.clear;

  t1ccx_sig_ins u_sig (
    .din   (in_octet),
    .frame (in_frame),
    .apply (modify_ok && sig_en),
    .a_bit (info.a_bit),
    .b_bit (info.b_bit),
    .dout  (after_sig)
  );

  t1ccx_zcs u_zcs (
    .din   (after_sig),
    .apply (modify_ok && zcs_en),
    .dout  (after_zcs)
  );

  always_comb begin
    final_oct = after_zcs;
    if (ralarm) final_oct[ALARM_POS] = 1'b0;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_octet <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_octet <= final_oct;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/t1ccx_tx_chk.sv
module t1ccx_tx_chk #(
  parameter int BANK_W = 8,
  parameter int NBANK  = 3,
  parameter int SLOT_W = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [7:0]              in_octet,
  input logic [SLOT_W-1:0]       in_slot,
  input logic [BANK_W-1:0]       clr_bank0,
  input logic [BANK_W-1:0]       clr_bank1,
  input logic [BANK_W-1:0]       clr_bank2,
  input logic                    sig_en,
  input logic                    zcs_en,
  input logic                    ralarm,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [7:0]              out_octet
);
  localparam int NCH = BANK_W * NBANK;

  logic [NCH-1:0] m;
  logic           c_ok, c_clear;

  always_comb begin
    m       = {clr_bank2, clr_bank1, clr_bank0};
    c_ok    = (int'(in_slot) >= 1) && (int'(in_slot) <= NCH);
    c_clear = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (c_ok && (int'(in_slot) == i + 1)) c_clear = m[i];
  end

  // R1
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_octet));

  // R1
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R6
  clear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && c_clear && !ralarm |=> out_octet == $past(in_octet));

  // R7
  alarm_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ralarm |=> !out_octet[6]);

  // R5
  no_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && zcs_en && c_ok && !c_clear && !ralarm |=> out_octet != 8'h00);

  // R8
  transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !sig_en && !zcs_en && !ralarm |=> out_octet == $past(in_octet));
endmodule

bind t1ccx_tx t1ccx_tx_chk #(.BANK_W(BANK_W), .NBANK(NBANK), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_octet(in_octet), .in_slot(in_slot), .clr_bank0(clr_bank0),
  .clr_bank1(clr_bank1), .clr_bank2(clr_bank2), .sig_en(sig_en),
  .zcs_en(zcs_en), .ralarm(ralarm), .out_valid(out_valid),
  .out_ready(out_ready), .out_octet(out_octet)
);

// File: tb/t1ccx_tx_bench.sv
`timescale 1ns/1ps
module t1ccx_tx_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_octet = 0;
  logic [4:0]  in_slot = 1;
  logic [3:0]  in_frame = 1;
  logic [23:0] sig_a = 0, sig_b = 0;
  logic [7:0]  clr_bank0 = 0, clr_bank1 = 0, clr_bank2 = 0;
  logic        sig_en = 0, zcs_en = 0, ralarm = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [7:0]  out_octet;

  int checks = 0, errors = 0;
  bit bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit   m_valid = 0;
  logic [7:0] m_oct = 0;
  string m_tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  t1ccx_tx u_t1ccx_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_octet(in_octet), .in_slot(in_slot), .in_frame(in_frame),
    .sig_a(sig_a), .sig_b(sig_b), .clr_bank0(clr_bank0),
    .clr_bank1(clr_bank1), .clr_bank2(clr_bank2), .sig_en(sig_en),
    .zcs_en(zcs_en), .ralarm(ralarm), .out_valid(out_valid),
    .out_ready(out_ready), .out_octet(out_octet)
  );

  function automatic logic [7:0] ref_oct(logic [7:0] o, int s, int f, output string tag);
    logic [23:0] msk;
    bit ok, clr;
    msk = {clr_bank2, clr_bank1, clr_bank0};
    ok  = (s >= 1) && (s <= 24);
    clr = ok && msk[s-1];
    tag = ok ? (clr ? "R3 R6" : "R8") : "R9";
    if (ok && !clr && sig_en) begin
      if (f == 6)  begin o[0] = sig_a[s-1]; tag = "R4"; end
      else if (f == 12) begin o[0] = sig_b[s-1]; tag = "R4"; end
    end
    if (ok && !clr && zcs_en && o == 8'h00) begin o = 8'h02; tag = "R5"; end
    if (ralarm) begin o[6] = 1'b0; tag = "R7"; end
    return o;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, evaluated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      m_valid = 0;
    end else begin
      bit rdy;
      string t;
      rdy = !m_valid || out_ready;
      check(out_valid == m_valid, "R1", out_valid, m_valid);
      check(in_ready == rdy, "R1", in_ready, rdy);
      if (m_valid) check(out_octet == m_oct, m_tag, out_octet, m_oct);
      if (in_valid && rdy) begin
        m_oct = ref_oct(in_octet, int'(in_slot), int'(in_frame), t);
        m_tag = t;
        m_valid = 1;
      end else if (out_ready) begin
        m_valid = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  task automatic send(logic [7:0] o, int s, int f);
    bit hs;
    in_valid = 1; in_octet = o; in_slot = 5'(s); in_frame = 4'(f);
    do begin
      @(negedge clk); hs = in_ready;
      @(posedge clk); #1;
    end while (!hs);
    in_valid = 0;
  endtask

  task automatic drain();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic sweep();
    for (int f = 1; f <= 12; f++)
      for (int s = 1; s <= 24; s++)
        send((s % 5 == 0) ? 8'h00 : ((s % 7 == 3) ? 8'h01 : 8'((s * 37 + f * 11) ^ 8'h5A)), s, f);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R2: reset state
    check(out_valid == 0, "R2", out_valid, 0);
    check(in_ready == 1, "R2", in_ready, 1);
    @(posedge clk); #1;

    sig_a = 24'hA5C3F0; sig_b = 24'h3C0FF5;
    sig_en = 1; zcs_en = 1;
    sweep();                                   // R4 R5 with no clear slots

    clr_bank0 = 8'h81; clr_bank1 = 8'h01; clr_bank2 = 8'h80;  // R3 edges of each bank
    bp_mode = 1;
    sweep();                                   // R6 with back-pressure (R1)

    ralarm = 1;
    sweep();                                   // R7 over clear and non-clear slots
    ralarm = 0;

    clr_bank0 = 8'h00; clr_bank1 = 8'hFF; clr_bank2 = 8'h00;
    sig_en = 0;
    sweep();                                   // R8 signaling disabled
    sig_en = 1; zcs_en = 0;
    sweep();                                   // R8 suppression disabled
    sig_en = 0; ralarm = 0;
    sweep();                                   // R8 fully transparent
    bp_mode = 0;

    sig_en = 1; zcs_en = 1;
    // R9: out-of-range slots and frames
    send(8'h00, 0, 6);  send(8'h00, 25, 12); send(8'h00, 31, 6);
    send(8'h00, 3, 0);  send(8'h00, 3, 13);  send(8'h00, 3, 15);
    send(8'h00, 1, 12); send(8'h00, 24, 6);
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule